// File: doc/BRIEF.md
# Execute Redirect Arbiter

This block sits at the execute stage of a multi-threaded out-of-order core. Each cycle it looks at the issued slots, which arrive oldest first in slot 0. It decides for every hardware thread whether the front end must be steered to a new address. Three conditions can demand this: a branch whose prediction turned out wrong, a memory-ordering violation, and a load that memory has refused and which must be replayed. Each instruction carries one input flag per condition. The arbiter itself does no prediction or disambiguation.

For every thread that redirects, the block emits a one-cycle record. The record holds the cause, the sequence number from which younger work is discarded, the address at which fetch resumes, whether the offending instruction itself is discarded, and, for branches, the resolved direction. It also keeps two running counts of wrong predictions: those where the corrected direction is not-taken (the branch was wrongly predicted taken) and those where it is taken. It reports their sum as well.

Top module: `redir_arbiter`

## Requirements
- R1: While reset is held and after it is released with no input activity, every `rd_valid` bit is 0 and all three counters read 0.
- R2: At most one record is produced per thread per cycle. Among eligible instructions of one thread, the lowest slot index (oldest) wins, and later instructions of that thread are ignored for that cycle.
- R3: Within one instruction the causes rank mispredict first, then ordering violation, then blocked load. Only the highest-ranking asserted cause is reported.
- R4: A mispredict gives cause code 1, restart address = the instruction's resolved next address, flush-self 0, and taken = 1 exactly when the next address differs from its address plus 4.
- R5: An ordering violation gives cause code 2, restart address = the instruction's next address, flush-self 0, and taken 0.
- R6: A blocked load gives cause code 3, restart address = the load's own address, and flush-self 1. It is eligible only while that thread's `mem_blocked` bit is 1 and the thread's blocked condition has not yet been handled.
- R7: A blocked-load redirect marks the thread's condition as handled, so no further blocked-load redirect occurs for that thread until its `mem_blocked` bit has been seen low for at least one cycle.
- R8: Slots with `in_valid` 0 or `in_squashed` 1 never produce a record and do not hide a younger eligible slot of the same thread.
- R9: `cnt_pred_taken_wrong` increments by one for each cause-1 record with taken 0, and `cnt_pred_nt_wrong` for each cause-1 record with taken 1, in the cycle the record appears. `cnt_mispred_total` equals their sum (all wrap at 2^CNT_W).
- R10: A record appears in the cycle after its inputs were presented and stays valid for exactly one cycle. It is valid again only if the next inputs also call for it.
- R11: Threads are arbitrated independently. Different threads may each produce a record in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | SLOTS | Slot holds an issued instruction |
| in_squashed | input | SLOTS | Instruction already discarded |
| in_tid | input | SLOTS*TID_W | Owning thread of each slot |
| in_seq | input | SLOTS*SEQ_W | Sequence number of each slot |
| in_pc | input | SLOTS*PC_W | Address of each instruction |
| in_npc | input | SLOTS*PC_W | Resolved next address of each instruction |
| in_mispred | input | SLOTS | Branch prediction found wrong |
| in_order_viol | input | SLOTS | Memory-ordering violation detected |
| in_ld_blocked | input | SLOTS | This instruction is the load memory refused |
| mem_blocked | input | THREADS | Per thread, memory currently reports a refused load |
| rd_valid | output | THREADS | Record valid for the thread |
| rd_cause | output | THREADS*2 | Cause code (1 branch, 2 ordering, 3 blocked load) |
| rd_seq | output | THREADS*SEQ_W | Flush sequence number |
| rd_pc | output | THREADS*PC_W | Restart address |
| rd_flush_self | output | THREADS | Offending instruction is discarded too |
| rd_taken | output | THREADS | Resolved branch direction |
| cnt_pred_taken_wrong | output | CNT_W | Mispredicts whose corrected direction is not-taken |
| cnt_pred_nt_wrong | output | CNT_W | Mispredicts whose corrected direction is taken |
| cnt_mispred_total | output | CNT_W | Sum of both mispredict counts |

## Verification
Directed cycles place one instruction with single and combined flags to separate the cause ranking and the address and flush rules of each cause. A pair of same-thread slots checks that age wins over cause, and a squashed older slot checks that it neither redirects nor hides a younger one. A blocked load repeated with `mem_blocked` held, then dropped and raised again, tells the handled flag apart from plain priority. A long pseudo-random sweep over all slots, both threads and mixed flags compares every record and the counters against an arithmetic model each cycle.

// File: rtl/redir_pkg.sv
package redir_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BRANCH  = 2'd1,
    CAUSE_ORDER   = 2'd2,
    CAUSE_BLOCKED = 2'd3
  } cause_e;
endpackage

// File: rtl/redir_slot_eval.sv
module redir_slot_eval
  import redir_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic            valid,
  input  logic            squashed,
  input  logic            mispred,
  input  logic            order_viol,
  input  logic            blk_ok,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] npc,
  output logic            cand,
  output logic [1:0]      cause,
  output logic [PC_W-1:0] restart_pc,
  output logic            flush_self,
  output logic            taken
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  cause_e c;

  // Per-instruction cause ranking and the restart rule of each cause
  always_comb begin
    c          = CAUSE_NONE;
    restart_pc = npc;
    flush_self = 1'b0;
    taken      = 1'b0;
    if (valid && !squashed) begin
      if (mispred) begin
        c     = CAUSE_BRANCH;
        taken = (npc != (pc + STEP));
      end else if (order_viol) begin
        c = CAUSE_ORDER;
      end else if (blk_ok) begin
        c          = CAUSE_BLOCKED;
        restart_pc = pc;
        flush_self = 1'b1;
      end
    end
  end

  assign cause = c;
  assign cand  = (c != CAUSE_NONE);
endmodule

// File: rtl/redir_thread_pick.sv
module redir_thread_pick #(
  parameter int SLOTS  = 4,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int THREAD = 0
) (
  input  logic [SLOTS-1:0]            cand,
  input  logic [SLOTS-1:0][TID_W-1:0] tid,
  input  logic [SLOTS-1:0][1:0]       cause,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
  input  logic [SLOTS-1:0][PC_W-1:0]  rpc,
  input  logic [SLOTS-1:0]            flush,
  input  logic [SLOTS-1:0]            taken,
  output logic                        hit,
  output logic [1:0]                  hit_cause,
  output logic [SEQ_W-1:0]            hit_seq,
  output logic [PC_W-1:0]             hit_pc,
  output logic                        hit_flush,
  output logic                        hit_taken
);
  localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD);

  // Walk youngest to oldest so the oldest matching slot is written last
  always_comb begin
    hit       = 1'b0;
    hit_cause = 2'd0;
    hit_seq   = '0;
    hit_pc    = '0;
    hit_flush = 1'b0;
    hit_taken = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (cand[s] && (tid[s] == MY_TID)) begin
        hit       = 1'b1;
        hit_cause = cause[s];
        hit_seq   = seq[s];
        hit_pc    = rpc[s];
        hit_flush = flush[s];
        hit_taken = taken[s];
      end
    end
  end
endmodule

// File: rtl/redir_mispred_ctr.sv
module redir_mispred_ctr #(
  parameter int THREADS = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] br_hit,
  input  logic [THREADS-1:0] br_taken,
  output logic [CNT_W-1:0]   cnt_ptk,
  output logic [CNT_W-1:0]   cnt_pnt,
  output logic [CNT_W-1:0]   cnt_sum
);
  logic [CNT_W-1:0] ptk_q, pnt_q, ptk_d, pnt_d;
  logic             cnt_en;

  always_comb begin
    ptk_d = ptk_q;
    pnt_d = pnt_q;
    for (int t = 0; t < THREADS; t++) begin
      if (br_hit[t] && !br_taken[t]) ptk_d = ptk_d + CNT_W'(1);
      if (br_hit[t] &&  br_taken[t]) pnt_d = pnt_d + CNT_W'(1);
    end
  end

  assign cnt_en = |br_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptk_q <= '0;
      pnt_q <= '0;
    end else if (cnt_en) begin
      ptk_q <= ptk_d;
      pnt_q <= pnt_d;
    end
  end

  assign cnt_ptk = ptk_q;
  assign cnt_pnt = pnt_q;
  assign cnt_sum = ptk_q + pnt_q;
endmodule

// File: rtl/redir_arbiter.sv
module redir_arbiter
  import redir_pkg::*;
#(
  parameter int THREADS    = 2,
  parameter int SLOTS      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         in_valid,
  input  logic [SLOTS-1:0]         in_squashed,
  input  logic [SLOTS*TID_W-1:0]   in_tid,
  input  logic [SLOTS*SEQ_W-1:0]   in_seq,
  input  logic [SLOTS*PC_W-1:0]    in_pc,
  input  logic [SLOTS*PC_W-1:0]    in_npc,
  input  logic [SLOTS-1:0]         in_mispred,
  input  logic [SLOTS-1:0]         in_order_viol,
  input  logic [SLOTS-1:0]         in_ld_blocked,
  input  logic [THREADS-1:0]       mem_blocked,
  output logic [THREADS-1:0]       rd_valid,
  output logic [THREADS*2-1:0]     rd_cause,
  output logic [THREADS*SEQ_W-1:0] rd_seq,
  output logic [THREADS*PC_W-1:0]  rd_pc,
  output logic [THREADS-1:0]       rd_flush_self,
  output logic [THREADS-1:0]       rd_taken,
  output logic [CNT_W-1:0]         cnt_pred_taken_wrong,
  output logic [CNT_W-1:0]         cnt_pred_nt_wrong,
  output logic [CNT_W-1:0]         cnt_mispred_total
);
  // Unpacked views of the flat slot buses
  logic [SLOTS-1:0][TID_W-1:0] tid_a;
  logic [SLOTS-1:0][SEQ_W-1:0] seq_a;
  logic [SLOTS-1:0][PC_W-1:0]  pc_a, npc_a;
  assign tid_a = in_tid;
  assign seq_a = in_seq;
  assign pc_a  = in_pc;
  assign npc_a = in_npc;

  // Per-thread blocked-load handled state
  logic [THREADS-1:0] handled_q, handled_d;

  // Slot evaluation
  logic [SLOTS-1:0]            s_cand, s_flush, s_taken, s_blk_ok;
  logic [SLOTS-1:0][1:0]       s_cause;
  logic [SLOTS-1:0][PC_W-1:0]  s_rpc;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      s_blk_ok[s] = 1'b0;
      if (int'(tid_a[s]) < THREADS)
        s_blk_ok[s] = in_ld_blocked[s] & mem_blocked[tid_a[s]] & ~handled_q[tid_a[s]];
    end

    redir_slot_eval #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_eval (
      .valid      (in_valid[s]),
      .squashed   (in_squashed[s]),
      .mispred    (in_mispred[s]),
      .order_viol (in_order_viol[s]),
      .blk_ok     (s_blk_ok[s]),
      .pc         (pc_a[s]),
      .npc        (npc_a[s]),
      .cand       (s_cand[s]),
      .cause      (s_cause[s]),
      .restart_pc (s_rpc[s]),
      .flush_self (s_flush[s]),
      .taken      (s_taken[s])
    );
  end

  // Per-thread selection and output registers
  logic [THREADS-1:0]            p_hit, p_flush, p_taken, br_hit;
  logic [THREADS-1:0][1:0]       p_cause;
  logic [THREADS-1:0][SEQ_W-1:0] p_seq;
  logic [THREADS-1:0][PC_W-1:0]  p_pc;

  logic [THREADS-1:0]            vld_q, vld_d, flush_q, taken_q;
  logic [THREADS-1:0][1:0]       cause_q;
  logic [THREADS-1:0][SEQ_W-1:0] seq_q;
  logic [THREADS-1:0][PC_W-1:0]  pc_q;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    redir_thread_pick #(
      .SLOTS(SLOTS), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W), .THREAD(t)
    ) u_pick (
      .cand      (s_cand),
      .tid       (tid_a),
      .cause     (s_cause),
      .seq       (seq_a),
      .rpc       (s_rpc),
      .flush     (s_flush),
      .taken     (s_taken),
      .hit       (p_hit[t]),
      .hit_cause (p_cause[t]),
      .hit_seq   (p_seq[t]),
      .hit_pc    (p_pc[t]),
      .hit_flush (p_flush[t]),
      .hit_taken (p_taken[t])
    );

    always_comb begin
      vld_d[t]     = p_hit[t];
      br_hit[t]    = p_hit[t] && (p_cause[t] == CAUSE_BRANCH);
      handled_d[t] = handled_q[t];
      if (!mem_blocked[t])
        handled_d[t] = 1'b0;
      else if (p_hit[t] && (p_cause[t] == CAUSE_BLOCKED))
        handled_d[t] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[t]     <= 1'b0;
        handled_q[t] <= 1'b0;
        cause_q[t]   <= 2'd0;
        seq_q[t]     <= '0;
        pc_q[t]      <= '0;
        flush_q[t]   <= 1'b0;
        taken_q[t]   <= 1'b0;
      end else begin
        vld_q[t]     <= vld_d[t];
        handled_q[t] <= handled_d[t];
        if (p_hit[t]) begin
          cause_q[t] <= p_cause[t];
          seq_q[t]   <= p_seq[t];
          pc_q[t]    <= p_pc[t];
          flush_q[t] <= p_flush[t];
          taken_q[t] <= p_taken[t];
        end
      end
    end

    assign rd_cause[2*t +: 2]         = cause_q[t];
    assign rd_seq[SEQ_W*t +: SEQ_W]   = seq_q[t];
    assign rd_pc[PC_W*t +: PC_W]      = pc_q[t];

    // R10
    valid_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[t] |-> (cause_q[t] != CAUSE_NONE));
    // R6
    blocked_flushes_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[t] && cause_q[t] == CAUSE_BLOCKED) |-> flush_q[t]);
    // R5
    order_keeps_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[t] && cause_q[t] == CAUSE_ORDER) |-> (!flush_q[t] && !taken_q[t]));
    // R4
    branch_keeps_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[t] && cause_q[t] == CAUSE_BRANCH) |-> !flush_q[t]);
    // R7
    blocked_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[t] && cause_q[t] == CAUSE_BLOCKED) |=>
        !(vld_q[t] && cause_q[t] == CAUSE_BLOCKED));
  end

  assign rd_valid      = vld_q;
  assign rd_flush_self = flush_q;
  assign rd_taken      = taken_q;

  redir_mispred_ctr #(.THREADS(THREADS), .CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_hit   (br_hit),
    .br_taken (p_taken),
    .cnt_ptk  (cnt_pred_taken_wrong),
    .cnt_pnt  (cnt_pred_nt_wrong),
    .cnt_sum  (cnt_mispred_total)
  );

  // Counter movement must coincide with a matching branch record
  logic out_br_nt, out_br_tk;
  always_comb begin
    out_br_nt = 1'b0;
    out_br_tk = 1'b0;
    for (int t = 0; t < THREADS; t++) begin
      if (vld_q[t] && cause_q[t] == CAUSE_BRANCH &&  taken_q[t]) out_br_tk = 1'b1;
      if (vld_q[t] && cause_q[t] == CAUSE_BRANCH && !taken_q[t]) out_br_nt = 1'b1;
    end
  end

  // R9
  ptk_moves_with_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pred_taken_wrong != $past(cnt_pred_taken_wrong)) |-> out_br_nt);
  // R9
  pnt_moves_with_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pred_nt_wrong != $past(cnt_pred_nt_wrong)) |-> out_br_tk);
endmodule

// File: tb/sim_redir_arbiter.sv
`timescale 1ns/1ps
module sim_redir_arbiter;
  localparam int T = 2;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [W-1:0]    v, sq, mp, ov, lb;
  logic [W-1:0]    tidv;
  logic [W*16-1:0] seqv;
  logic [W*32-1:0] pcv, npcv;
  logic [T-1:0]    mb;

  logic [T-1:0]    rd_valid, rd_flush_self, rd_taken;
  logic [T*2-1:0]  rd_cause;
  logic [T*16-1:0] rd_seq;
  logic [T*32-1:0] rd_pc;
  logic [15:0]     c_ptk, c_pnt, c_tot;

  redir_arbiter u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(v), .in_squashed(sq), .in_tid(tidv), .in_seq(seqv),
    .in_pc(pcv), .in_npc(npcv), .in_mispred(mp), .in_order_viol(ov),
    .in_ld_blocked(lb), .mem_blocked(mb),
    .rd_valid(rd_valid), .rd_cause(rd_cause), .rd_seq(rd_seq), .rd_pc(rd_pc),
    .rd_flush_self(rd_flush_self), .rd_taken(rd_taken),
    .cnt_pred_taken_wrong(c_ptk), .cnt_pred_nt_wrong(c_pnt),
    .cnt_mispred_total(c_tot)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [T-1:0] hd;
  logic [15:0]  e_ptk, e_pnt;
  logic [31:0]  rng;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_slots();
    v = '0; sq = '0; mp = '0; ov = '0; lb = '0; tidv = '0;
    seqv = '0; pcv = '0; npcv = '0;
  endtask

  task automatic set_slot(input int s, input logic sqb, input logic t,
                          input logic [15:0] sn, input logic [31:0] pc,
                          input logic [31:0] npc, input logic m, input logic o,
                          input logic l);
    v[s] = 1'b1; sq[s] = sqb; tidv[s] = t;
    seqv[16*s +: 16] = sn; pcv[32*s +: 32] = pc; npcv[32*s +: 32] = npc;
    mp[s] = m; ov[s] = o; lb[s] = l;
  endtask

  // Model from the requirements, then one clock, then compare
  task automatic run_cycle(input string tag);
    logic [T-1:0] ev, ef, et, blk_hit;
    logic [1:0]   ec [T];
    logic [15:0]  es [T];
    logic [31:0]  ep [T];
    for (int t = 0; t < T; t++) begin
      ev[t] = 0; ef[t] = 0; et[t] = 0; ec[t] = 0; es[t] = 0; ep[t] = 0; blk_hit[t] = 0;
      for (int s = 0; s < W; s++) begin
        if (!ev[t] && v[s] && !sq[s] && int'(tidv[s]) == t) begin
          logic [31:0] pc_s, npc_s;
          pc_s = pcv[32*s +: 32]; npc_s = npcv[32*s +: 32];
          if (mp[s]) begin
            ev[t] = 1; ec[t] = 1; ep[t] = npc_s; et[t] = (npc_s != pc_s + 32'd4);
          end else if (ov[s]) begin
            ev[t] = 1; ec[t] = 2; ep[t] = npc_s;
          end else if (lb[s] && mb[t] && !hd[t]) begin
            ev[t] = 1; ec[t] = 3; ep[t] = pc_s; ef[t] = 1; blk_hit[t] = 1;
          end
          if (ev[t]) es[t] = seqv[16*s +: 16];
        end
      end
    end
    for (int t = 0; t < T; t++)
      if (ev[t] && ec[t] == 1) begin
        if (et[t]) e_pnt = e_pnt + 16'd1; else e_ptk = e_ptk + 16'd1;
      end
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < T; t++) begin
      check({tag, " valid"}, 64'(rd_valid[t]), 64'(ev[t]));
      if (ev[t])
        check({tag, " record"},
              64'({rd_cause[2*t +: 2], rd_seq[16*t +: 16], rd_pc[32*t +: 32],
                   rd_flush_self[t], rd_taken[t]}),
              64'({ec[t], es[t], ep[t], ef[t], et[t]}));
      if (!mb[t]) hd[t] = 0; else if (blk_hit[t]) hd[t] = 1;
    end
    // R9 counters and their sum
    check("R9 counters", 64'({c_ptk, c_pnt, c_tot}),
          64'({e_ptk, e_pnt, 16'(e_ptk + e_pnt)}));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_slots(); mb = '0; hd = '0; e_ptk = 0; e_pnt = 0; rng = 32'h1234_5678;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(rd_valid), 64'd0);
    check("R1 counters", 64'({c_ptk, c_pnt, c_tot}), 64'd0);
    rst_n = 1'b1;
    run_cycle("R1");

    // R4 mispredict, both directions
    clear_slots(); set_slot(0, 0, 0, 16'h0010, 32'h100, 32'h200, 1, 0, 0); run_cycle("R4");
    clear_slots(); set_slot(0, 0, 1, 16'h0011, 32'h300, 32'h304, 1, 0, 0); run_cycle("R4");
    // R5 ordering violation
    clear_slots(); set_slot(2, 0, 0, 16'h0020, 32'h400, 32'h404, 0, 1, 0); run_cycle("R5");
    // R3 ranking
    mb = 2'b01;
    clear_slots(); set_slot(0, 0, 0, 16'h0030, 32'h500, 32'h504, 1, 1, 1); run_cycle("R3");
    clear_slots(); set_slot(0, 0, 0, 16'h0031, 32'h600, 32'h680, 0, 1, 1); run_cycle("R3");
    // R6 blocked load on thread 1
    mb = 2'b10;
    clear_slots(); set_slot(1, 0, 1, 16'h0040, 32'h700, 32'h704, 0, 0, 1); run_cycle("R6");
    // R7 handled: no repeat while held, rearm after low
    run_cycle("R7");
    mb = 2'b00; run_cycle("R7");
    mb = 2'b10; run_cycle("R7");
    // R8 squashed older slot neither redirects nor hides younger
    mb = 2'b00;
    clear_slots();
    set_slot(0, 1, 0, 16'h0050, 32'h800, 32'h900, 1, 0, 0);
    set_slot(1, 0, 0, 16'h0051, 32'h804, 32'h808, 0, 1, 0);
    run_cycle("R8");
    // R2 oldest wins over higher-ranked younger
    clear_slots();
    set_slot(1, 0, 0, 16'h0060, 32'hA00, 32'hA04, 0, 1, 0);
    set_slot(2, 0, 0, 16'h0061, 32'hA04, 32'hB00, 1, 0, 0);
    run_cycle("R2");
    // R11 both threads in one cycle
    clear_slots();
    set_slot(0, 0, 1, 16'h0070, 32'hC00, 32'hC04, 0, 1, 0);
    set_slot(1, 0, 0, 16'h0071, 32'hC10, 32'hD00, 1, 0, 0);
    run_cycle("R11");
    // R10 record lasts one cycle
    clear_slots(); run_cycle("R10");

    // Sweep
    for (int n = 0; n < 3000; n++) begin
      clear_slots();
      if (rng[7:4] == 4'd0) mb = mb ^ rng[9:8];
      for (int s = 0; s < W; s++) begin
        logic [31:0] pcr;
        rng = rng * 32'd1103515245 + 32'd12345;
        pcr = {rng[31:20], 2'b00} + 32'h1000;
        set_slot(s, rng[19:17] == 3'd0, rng[16], rng[15:0],
                 pcr, rng[14] ? pcr + 32'd4 : {rng[27:16], 2'b00},
                 rng[13:11] == 3'd0, rng[10:8] == 3'd0, rng[7:6] == 2'd0);
        v[s] = rng[5:3] != 3'd0;
      end
      run_cycle("R2 sweep");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule